// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading two table entries from memory. A translation request carries the virtual address and the number of the requesting master. The block fetches the entry of the first-level table that the upper address bits select. That entry names a second-level table. The block then fetches the entry of that table that the middle address bits select. The second-level entry supplies the page frame and a 4-bit permission-domain index. Both are returned with the translation.

A malformed entry at either level ends the walk with a fault of that level. The faulting address and the blamed master are recorded in a per-level log that stays visible on plain output pins. When the global enable input is low, each request comes back untranslated one cycle after it is accepted, and no memory read is made.

Both the request and the response sides are valid/ready streams. A request is taken only when `req_ready` is high. The block holds one request at a time and keeps `req_ready` low from acceptance until its response has been taken. A response stays on `rsp_valid` with stable payload for as long as `rsp_ready` is low. On the memory side, a read request is held with a stable address until `mem_req_ready` is seen. The block never has more than one read outstanding. A read response is a one-cycle `mem_rsp_valid` pulse with data; it has no ready.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0. Both error-address outputs and both blame vectors are 0.
- R2: The first read of a walk goes to byte address `tbl_base + 4*va[31:20]`. It appears on `mem_req_addr` as a word address, which is that byte address shifted right by 2.
- R3: The second read goes to byte address `{L1entry[31:10], va[19:12], 2'b00}`. Bits 9:2 of the first-level entry have no effect on it.
- R4: A first-level entry counts as valid only when its bits 1:0 equal 2'b01. The values 00, 10 and 11 end the walk with `rsp_fault_l1`=1, `rsp_fault_l2`=0, `rsp_paddr`=0 and `rsp_domain`=0. No second read is issued.
- R5: A second-level entry counts as valid when its bit 1 is 1. The response is then `rsp_paddr = {L2entry[31:12], va[11:0]}` and `rsp_domain = L2entry[7:4]`, with both fault flags 0. Bits 11:8, 3:2 and 0 of the entry have no effect.
- R6: A second-level entry with bit 1 equal to 0 ends the walk with `rsp_fault_l2`=1, `rsp_fault_l1`=0, `rsp_paddr`=0 and `rsp_domain`=0.
- R7: Each fault level keeps its own log. A fault loads that level's error-address output with the virtual address and its blame vector with a one-hot value that has bit m set for master m. The log of the other level is left unchanged.
- R8: With `walk_en`=0 when a request is accepted, the response appears in the next cycle with `rsp_paddr` equal to the request address, `rsp_domain`=0 and no fault. No memory read is made.
- R9: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is high. At most one read is outstanding at a time. A walk completes correctly whatever the stall pattern on `mem_req_ready`.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response payload stays stable and `req_ready` stays 0. The response is removed in the cycle after `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_en | input | 1 | Global translation enable, sampled when a request is accepted |
| tbl_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual address to translate |
| req_master | input | 3 | Number of the requesting master |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_domain | output | 4 | Permission-domain index from the second-level entry |
| rsp_fault_l1 | output | 1 | Walk ended on an invalid first-level entry |
| rsp_fault_l2 | output | 1 | Walk ended on an invalid second-level entry |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 30 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rsp_data | input | 32 | Read data |
| l1_err_addr | output | 32 | Virtual address of the last first-level fault |
| l1_err_blame | output | 6 | One-hot master of the last first-level fault |
| l2_err_addr | output | 32 | Virtual address of the last second-level fault |
| l2_err_blame | output | 6 | One-hot master of the last second-level fault |

## Verification
The hardest case to reach from the ports is a walk in which the memory request is held off for several cycles while the consumer also refuses the response. In that case the stable-request, single-outstanding and response-hold rules must all hold together. The stimulus reaches it through the bench memory model, which can switch to a mode that grants `mem_req_ready` only one cycle in four. A later walk then holds `rsp_ready` low for several cycles after the result appears. First-level faults are provoked with each of the three invalid low-bit codes in turn. The logs are then read back after a following second-level fault, which shows that each level keeps its own record.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_ISSUE,
    S_L1_WAIT,
    S_L2_ISSUE,
    S_L2_WAIT,
    S_DONE
  } walk_state_t;

  localparam logic [1:0] DIR_VALID_CODE = 2'b01;
  localparam int         PAGE_VALID_BIT = 1;
  localparam int         DOM_LSB        = 4;
  localparam int         DOM_W          = 4;
endpackage

// File: rtl/xw_entry_decode.sv
module xw_entry_decode #(
  parameter int PT_ALIGN  = 10,
  parameter int PAGE_BITS = 12
) (
  input  logic [31:0]           word,
  output logic                  dir_ok,
  output logic [31:PT_ALIGN]    dir_table,
  output logic                  page_ok,
  output logic [31:PAGE_BITS]   page_frame,
  output logic [xw_pkg::DOM_W-1:0] page_domain
);
  import xw_pkg::*;

  assign dir_ok      = (word[1:0] == DIR_VALID_CODE);
  assign dir_table   = word[31:PT_ALIGN];
  assign page_ok     = word[PAGE_VALID_BIT];
  assign page_frame  = word[31:PAGE_BITS];
  assign page_domain = word[DOM_LSB +: DOM_W];
endmodule

// File: rtl/xw_fault_log.sv
module xw_fault_log #(
  parameter int NUM_MASTERS = 6,
  parameter int MID_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [31:0]            va,
  input  logic [MID_W-1:0]       mid,
  output logic [31:0]            err_addr,
  output logic [NUM_MASTERS-1:0] blame
);
  localparam logic [NUM_MASTERS-1:0] ONE = NUM_MASTERS'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_addr <= '0;
      blame    <= '0;
    end else if (capture) begin
      err_addr <= va;
      blame    <= ONE << mid;
    end
  end
endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic walk_en,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic dir_ok,
  input  logic page_ok,
  output logic req_ready,
  output logic rsp_valid,
  output logic mem_req_valid,
  output logic sel_l2,
  output logic ev_dir_good,
  output logic ev_dir_bad,
  output logic ev_page_good,
  output logic ev_page_bad
);
  import xw_pkg::*;

  walk_state_t st_q, st_d;

  assign req_ready     = (st_q == S_IDLE);
  assign rsp_valid     = (st_q == S_DONE);
  assign mem_req_valid = (st_q == S_L1_ISSUE) || (st_q == S_L2_ISSUE);
  assign sel_l2        = (st_q == S_L2_ISSUE);

  assign ev_dir_good  = (st_q == S_L1_WAIT) && mem_rsp_valid && dir_ok;
  assign ev_dir_bad   = (st_q == S_L1_WAIT) && mem_rsp_valid && !dir_ok;
  assign ev_page_good = (st_q == S_L2_WAIT) && mem_rsp_valid && page_ok;
  assign ev_page_bad  = (st_q == S_L2_WAIT) && mem_rsp_valid && !page_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:     if (req_valid) st_d = walk_en ? S_L1_ISSUE : S_DONE;
      S_L1_ISSUE: if (mem_req_ready) st_d = S_L1_WAIT;
      S_L1_WAIT:  if (mem_rsp_valid) st_d = dir_ok ? S_L2_ISSUE : S_DONE;
      S_L2_ISSUE: if (mem_req_ready) st_d = S_L2_WAIT;
      S_L2_WAIT:  if (mem_rsp_valid) st_d = S_DONE;
      S_DONE:     if (rsp_ready) st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int NUM_MASTERS = 6,
  parameter int L1_BITS     = 12,
  parameter int L2_BITS     = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               walk_en,
  input  logic [31:0]                        tbl_base,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [31:0]                        req_addr,
  input  logic [$clog2(NUM_MASTERS)-1:0]     req_master,
  output logic                               rsp_valid,
  input  logic                               rsp_ready,
  output logic [31:0]                        rsp_paddr,
  output logic [3:0]                         rsp_domain,
  output logic                               rsp_fault_l1,
  output logic                               rsp_fault_l2,
  output logic                               mem_req_valid,
  input  logic                               mem_req_ready,
  output logic [29:0]                        mem_req_addr,
  input  logic                               mem_rsp_valid,
  input  logic [31:0]                        mem_rsp_data,
  output logic [31:0]                        l1_err_addr,
  output logic [NUM_MASTERS-1:0]             l1_err_blame,
  output logic [31:0]                        l2_err_addr,
  output logic [NUM_MASTERS-1:0]             l2_err_blame
);
  localparam int MID_W     = $clog2(NUM_MASTERS);
  localparam int PAGE_BITS = 32 - L1_BITS - L2_BITS;
  localparam int PT_ALIGN  = L2_BITS + 2;
  localparam int NLEVELS   = 2;

  logic                   sel_l2;
  logic                   ev_dir_good, ev_dir_bad, ev_page_good, ev_page_bad;
  logic                   dir_ok, page_ok;
  logic [31:PT_ALIGN]     dir_table;
  logic [31:PAGE_BITS]    page_frame;
  logic [3:0]             page_domain;

  logic [31:0]            va_q;
  logic [MID_W-1:0]       mid_q;
  logic [31:PT_ALIGN]     pt_base_q;
  logic [31:0]            pa_q;
  logic [3:0]             dom_q;
  logic                   f1_q, f2_q;
  logic                   accept;

  logic [31:0]            l1_byte, l2_byte;

  xw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_en       (walk_en),
    .req_valid     (req_valid),
    .rsp_ready     (rsp_ready),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .dir_ok        (dir_ok),
    .page_ok       (page_ok),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .sel_l2        (sel_l2),
    .ev_dir_good   (ev_dir_good),
    .ev_dir_bad    (ev_dir_bad),
    .ev_page_good  (ev_page_good),
    .ev_page_bad   (ev_page_bad)
  );

  xw_entry_decode #(.PT_ALIGN(PT_ALIGN), .PAGE_BITS(PAGE_BITS)) u_dec (
    .word        (mem_rsp_data),
    .dir_ok      (dir_ok),
    .dir_table   (dir_table),
    .page_ok     (page_ok),
    .page_frame  (page_frame),
    .page_domain (page_domain)
  );

  assign accept = req_valid && req_ready;

  // Table entry addresses (byte), then word address on the port
  assign l1_byte = tbl_base + {{(30 - L1_BITS){1'b0}}, va_q[31 -: L1_BITS], 2'b00};
  assign l2_byte = {pt_base_q, va_q[PAGE_BITS +: L2_BITS], 2'b00};
  assign mem_req_addr = sel_l2 ? l2_byte[31:2] : l1_byte[31:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= '0;
      mid_q     <= '0;
      pt_base_q <= '0;
      pa_q      <= '0;
      dom_q     <= '0;
      f1_q      <= 1'b0;
      f2_q      <= 1'b0;
    end else begin
      if (accept) begin
        va_q  <= req_addr;
        mid_q <= req_master;
        pa_q  <= req_addr;
        dom_q <= '0;
        f1_q  <= 1'b0;
        f2_q  <= 1'b0;
      end
      if (ev_dir_good) pt_base_q <= dir_table;
      if (ev_dir_bad) begin
        pa_q  <= '0;
        dom_q <= '0;
        f1_q  <= 1'b1;
      end
      if (ev_page_good) begin
        pa_q  <= {page_frame, va_q[PAGE_BITS-1:0]};
        dom_q <= page_domain;
      end
      if (ev_page_bad) begin
        pa_q  <= '0;
        dom_q <= '0;
        f2_q  <= 1'b1;
      end
    end
  end

  assign rsp_paddr    = pa_q;
  assign rsp_domain   = dom_q;
  assign rsp_fault_l1 = f1_q;
  assign rsp_fault_l2 = f2_q;

  // One fault log per table level
  logic [NLEVELS-1:0]     lvl_cap;
  logic [31:0]            lvl_addr  [NLEVELS];
  logic [NUM_MASTERS-1:0] lvl_blame [NLEVELS];

  assign lvl_cap = {ev_page_bad, ev_dir_bad};

  for (genvar g = 0; g < NLEVELS; g++) begin : g_log
    xw_fault_log #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (lvl_cap[g]),
      .va       (va_q),
      .mid      (mid_q),
      .err_addr (lvl_addr[g]),
      .blame    (lvl_blame[g])
    );
  end

  assign l1_err_addr  = lvl_addr[0];
  assign l1_err_blame = lvl_blame[0];
  assign l2_err_addr  = lvl_addr[1];
  assign l2_err_blame = lvl_blame[1];
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
  parameter int NUM_MASTERS = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           walk_en,
  input logic                           req_valid,
  input logic                           req_ready,
  input logic [31:0]                    req_addr,
  input logic                           rsp_valid,
  input logic                           rsp_ready,
  input logic [31:0]                    rsp_paddr,
  input logic [3:0]                     rsp_domain,
  input logic                           rsp_fault_l1,
  input logic                           rsp_fault_l2,
  input logic                           mem_req_valid,
  input logic                           mem_req_ready,
  input logic [29:0]                    mem_req_addr,
  input logic                           mem_rsp_valid,
  input logic [NUM_MASTERS-1:0]         l1_err_blame,
  input logic [NUM_MASTERS-1:0]         l2_err_blame
);
  logic [1:0] outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else        outst <= outst + 2'(mem_req_valid && mem_req_ready) - 2'(mem_rsp_valid);
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> outst == 2'd0);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_domain)
      && $stable(rsp_fault_l1) && $stable(rsp_fault_l2));

  a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r4_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault_l1 && rsp_fault_l2));

  a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault_l1 || rsp_fault_l2) |-> rsp_paddr == 32'd0 && rsp_domain == 4'd0);

  a_r7_blame_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l1_err_blame) && $onehot0(l2_err_blame));

  a_r8_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !walk_en |=> rsp_valid && rsp_paddr == $past(req_addr)
      && !mem_req_valid);
endmodule

bind xlat_walker xw_checker #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_en       (walk_en),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_domain    (rsp_domain),
  .rsp_fault_l1  (rsp_fault_l1),
  .rsp_fault_l2  (rsp_fault_l2),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .l1_err_blame  (l1_err_blame),
  .l2_err_blame  (l2_err_blame)
);

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_en = 1'b1;
  logic [31:0] tbl_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_master = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_domain;
  logic        rsp_fault_l1, rsp_fault_l2;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [29:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] l1_err_addr, l2_err_addr;
  logic [5:0]  l1_err_blame, l2_err_blame;

  always #5 clk = ~clk;

  xlat_walker dut (
    .clk(clk), .rst_n(rst_n), .walk_en(walk_en), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_master(req_master),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain),
    .rsp_fault_l1(rsp_fault_l1), .rsp_fault_l2(rsp_fault_l2),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .l1_err_addr(l1_err_addr), .l1_err_blame(l1_err_blame),
    .l2_err_addr(l2_err_addr), .l2_err_blame(l2_err_blame)
  );

  // Memory model: sparse word store, read data one cycle after the handshake
  logic [31:0] mem [logic [29:0]];
  logic [29:0] rd_log [256];
  int          rd_cnt = 0;
  logic        stall_mode = 1'b0;
  logic [1:0]  rdy_ctr = '0;

  always @(posedge clk) begin
    rdy_ctr <= rdy_ctr + 2'd1;
    mem_req_ready <= stall_mode ? (rdy_ctr == 2'd3) : 1'b1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'd0;
      rd_log[rd_cnt % 256] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Results of the last translation
  logic [31:0] r_pa;
  logic [3:0]  r_dom;
  logic        r_f1, r_f2;
  int          r_lat;
  int          r_reads;
  int          r_first;

  task automatic xlat(input logic [31:0] va, input logic [2:0] m, input int hold);
    int start;
    @(negedge clk);
    start = rd_cnt;
    r_first = start;
    rsp_ready = (hold == 0);
    req_addr = va;
    req_master = m;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid) begin
      r_lat++;
      @(negedge clk);
    end
    r_pa = rsp_paddr; r_dom = rsp_domain; r_f1 = rsp_fault_l1; r_f2 = rsp_fault_l2;
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R10 valid held", {31'd0, rsp_valid}, 32'd1);
        chk("R10 paddr stable", rsp_paddr, r_pa);
        chk("R10 no accept", {31'd0, req_ready}, 32'd0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R10 released", {31'd0, rsp_valid}, 32'd0);
    end else begin
      @(negedge clk);
    end
    r_reads = rd_cnt - start;
  endtask

  function automatic logic [29:0] l1_word(input logic [31:0] va);
    logic [31:0] b;
    b = tbl_base + 32'(va[31:20]) * 4;
    return b[31:2];
  endfunction

  task automatic t_reset();
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 l1 log", l1_err_addr | 32'(l1_err_blame), 32'd0);
    chk("R1 l2 log", l2_err_addr | 32'(l2_err_blame), 32'd0);
  endtask

  task automatic t_walk_basic();
    logic [31:0] va = 32'h1234_5678;
    mem[l1_word(va)] = 32'h0020_03FD;            // bits 9:2 set, code 01
    mem[30'h0020_0114 >> 2] = 32'hABCD_EF7F;     // frame ABCDE, domain 7, junk bits set
    xlat(va, 3'd2, 0);
    chk("R2 first read addr", 32'(rd_log[r_first % 256]), 32'(l1_word(va)));
    chk("R3 second read addr", 32'(rd_log[(r_first + 1) % 256]), 32'(30'h0020_0114 >> 2));
    chk("R5 paddr", r_pa, 32'hABCD_E678);
    chk("R5 domain", 32'(r_dom), 32'd7);
    chk("R5 no fault", {30'd0, r_f1, r_f2}, 32'd0);
    chk("R3 two reads", r_reads, 2);
  endtask

  task automatic t_l1_codes();
    logic [1:0] codes [3] = '{2'b00, 2'b10, 2'b11};
    for (int k = 0; k < 3; k++) begin
      logic [31:0] va;
      va = {12'h300 + 12'(k), 20'h0_0ABC};
      mem[l1_word(va)] = {30'h0008_0000, codes[k]};
      xlat(va, 3'(k + 3), 0);
      chk("R4 l1 fault", {30'd0, r_f1, r_f2}, 32'd2);
      chk("R4 paddr zero", r_pa, 32'd0);
      chk("R4 single read", r_reads, 1);
      chk("R7 l1 addr", l1_err_addr, va);
      chk("R7 l1 blame", 32'(l1_err_blame), 32'd1 << (k + 3));
    end
  endtask

  task automatic t_l2_fault();
    logic [31:0] va = 32'h0051_2345;
    mem[l1_word(va)] = 32'h0040_0001;
    mem[30'h0040_0048 >> 2] = 32'hFFFF_FFFD;     // bit 1 clear
    xlat(va, 3'd1, 0);
    chk("R6 l2 fault", {30'd0, r_f1, r_f2}, 32'd1);
    chk("R6 domain zero", 32'(r_dom), 32'd0);
    chk("R7 l2 addr", l2_err_addr, va);
    chk("R7 l2 blame", 32'(l2_err_blame), 32'd2);
    chk("R7 l1 log kept", l1_err_addr, {12'h302, 20'h0_0ABC});
  endtask

  task automatic t_bypass();
    walk_en = 1'b0;
    xlat(32'hDEAD_BEEF, 3'd0, 0);
    chk("R8 paddr", r_pa, 32'hDEAD_BEEF);
    chk("R8 latency", r_lat, 0);
    chk("R8 no reads", r_reads, 0);
    chk("R8 clean", {27'd0, r_dom, r_f1}, 32'd0);
    walk_en = 1'b1;
  endtask

  task automatic t_stall_hold();
    logic [31:0] va = 32'hFFF0_1001;
    stall_mode = 1'b1;
    mem[l1_word(va)] = 32'h0060_0401;
    mem[30'h0060_0404 >> 2] = 32'h1357_90F2;
    xlat(va, 3'd5, 4);
    chk("R9 paddr under stall", r_pa, 32'h1357_9001);
    chk("R9 domain under stall", 32'(r_dom), 32'hF);
    chk("R9 reads", r_reads, 2);
    stall_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_walk_basic();
    t_l1_codes();
    t_l2_fault();
    t_bypass();
    t_stall_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule